// File: doc/BRIEF.md
# Serial Management Register Slave

This block sits on the PHY side of a two-wire management link. It watches the management clock and the bidirectional data line. It recognises frames addressed to its configured PHY address and serves a small bank of 16-bit control and status registers. Reads shift the selected register back onto the data line. The block drives a separate enable so that the pad can tristate the line. Writes update the control fields, which leave the block as plain configuration pins for the rest of the PHY.

The whole block runs on one fast system clock. The management clock and the data line are synchronised and sampled as edges. A line bit is taken on each rising management-clock edge. Read data is launched on the falling edge, so it is stable before the station samples it. The register bank has four special kinds of bit:
- a self-clearing software reset;
- status bits that latch high and clear on a read;
- a one-shot write gate that guards the crossover-mode bits;
- identifier registers built from a 24-bit organisation code.

Status conditions come in as plain level signals. No data stream passes through the block, so all of its pins are plain control and status pins with no valid/ready handshake.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive one bits followed by the start pattern 0 then 1. A frame with 31 or fewer preamble ones has no effect.
- R2: After the start pattern come a 2-bit opcode, a 5-bit PHY address and a 5-bit register address, each sent MSB first. A frame whose PHY address differs from `phy_addr` changes nothing and drives nothing.
- R3: Opcode 01 is a write. Two turnaround bits follow, then 16 data bits MSB first, and the addressed register is updated after the last data bit.
- R4: Opcode 10 is a read. During the first turnaround bit `mdio_oe` is 0. During the second, `mdio_oe` is 1 and `mdio_out` is 0. The 16 register bits then follow MSB first.
- R5: After reset, register 0 reads 0x3000. Its fields are: bit 14 loopback, bit 13 speed select, bit 12 auto-negotiation enable, bit 11 power down and bit 8 full duplex. All its other bits read 0.
- R6: Register 2 reads 0x0015. Register 3 reads 0xF443: the upper six code bits 111101, model 6'h04 and revision 4'h3. Both values are derived from the organisation code 00A0BEh.
- R7: Reserved bits read 0, and writing ones to them has no effect. Unimplemented register addresses, such as 5, read 0x0000.
- R8: Writing 1 to register 0 bit 15 returns every register to its default: register 0 to 0x3000, register 19 to 0x0300 and the override gate to 0. Bit 15 always reads 0.
- R9: Register 1 bit 4 (remote fault), register 1 bit 1 (jabber) and register 17 bit 8 (false carrier) latch high. Each reads 1 once its condition has occurred. It returns to the live condition value in the cycle after its register is read.
- R10: The auto-negotiation-complete input appears live in both register 1 bit 5 and register 17 bit 4. Register 1 also has capability bits 0x7809 set and live link status in bit 2. Register 17 has bit 15 speed, bit 14 duplex and bit 0 link.
- R11: Register 19 has bits 9:8 crossover mode, default 11 and write-protected, and bit 7 transmit tristate, read/write. The crossover bits change only on a write made while the gate (register 16 bit 15) is set. Any write other than one that sets the gate clears the gate again.
- R12: The ports `loopback_en`, `speed_sel`, `an_enable`, `power_down`, `full_duplex`, `xover_mode` and `tx_tristate` follow their register fields.
- R13: `mdio_oe` is 0 whenever no read is returning data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Configured PHY address |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Data line as seen at the pad |
| mdio_out | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| link_up | input | 1 | Live link status |
| an_complete | input | 1 | Auto-negotiation finished |
| remote_fault | input | 1 | Remote fault condition |
| jabber | input | 1 | Jabber condition |
| false_carrier | input | 1 | False carrier condition |
| loopback_en | output | 1 | Loopback control field |
| speed_sel | output | 1 | Speed select field |
| an_enable | output | 1 | Auto-negotiation enable field |
| power_down | output | 1 | Power-down field |
| full_duplex | output | 1 | Duplex field |
| xover_mode | output | 2 | Protected crossover-mode field |
| tx_tristate | output | 1 | Transmit tristate field |

## Verification
The bench sends a frame with exactly 31 preamble ones and another with a foreign PHY address. A slave that counted one bit short, or skipped the address compare, would overwrite register 0. It pulses fault conditions between frames and reads each status register twice. A latch that cleared too early, or never cleared, shows the wrong bit on the first read or on the second. It writes the crossover field without the gate, with the gate, and once more without re-arming the gate. A gate that did not consume itself would let the third write through. The bench also checks the turnaround timing on every read. A driver enabled one bit early would fight the station during the first turnaround bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    FS_HUNT, FS_START, FS_OPC, FS_PHYAD, FS_REGAD, FS_TURN1, FS_TURN2, FS_DATA
  } frame_state_e;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] RA_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] RA_ID_HI = 5'd2;
  localparam logic [ADDR_W-1:0] RA_ID_LO = 5'd3;
  localparam logic [ADDR_W-1:0] RA_GATE  = 5'd16;
  localparam logic [ADDR_W-1:0] RA_POLL  = 5'd17;
  localparam logic [ADDR_W-1:0] RA_XCTL  = 5'd19;

  localparam logic [REG_W-1:0] STAT_CAPS = 16'h7809;

  // Organisation code as a transmitted bit stream: octets in order, each
  // octet least significant bit first; stream bit 1 lands at index 23.
  function automatic logic [23:0] code_stream(input logic [23:0] code);
    logic [23:0] s;
    s = '0;
    for (int o = 0; o < 3; o++) begin
      for (int b = 0; b < 8; b++) begin
        s[23 - 8*o - b] = code[23 - 8*o - 7 + b];
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/mdio_line_sync.sv
module mdio_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic             edge_rise,
  output logic             edge_fall
);

  logic ref_prev;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

  // Edge detection on line 0, the reference clock line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= dout[0];
  end

  assign edge_rise = dout[0] & ~ref_prev;
  assign edge_fall = ~dout[0] & ref_prev;

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_bit,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [REG_W-1:0]  rd_data,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              mdio_out,
  output logic              mdio_oe
);

  localparam int unsigned CNT_W = $clog2(PRE_MIN + 1);
  localparam int unsigned BIT_W = $clog2(REG_W);
  localparam logic [CNT_W-1:0] PRE_LIM = CNT_W'(PRE_MIN);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_W - 1);
  localparam logic [BIT_W-1:0] ADDR_LAST = BIT_W'(ADDR_W - 1);

  frame_state_e      st;
  logic [CNT_W-1:0]  pre_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [REG_W-1:0]  sh;
  logic              is_rd;
  logic              cap_pend;
  logic              wr_pend;

  logic [ADDR_W-1:0] reg_next;
  logic              hdr_ok;

  assign reg_next = {reg_q[ADDR_W-2:0], mdio_bit};
  assign hdr_ok   = (phy_q == phy_addr) && ((opc == OPC_RD) || (opc == OPC_WR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FS_HUNT;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
      opc      <= '0;
      phy_q    <= '0;
      reg_q    <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      cap_pend <= 1'b0;
      wr_pend  <= 1'b0;
    end else begin
      cap_pend <= 1'b0;
      wr_pend  <= 1'b0;
      if (cap_pend) sh <= rd_data;
      if (mdc_rise) begin
        unique case (st)
          FS_HUNT: begin
            if (mdio_bit) begin
              if (pre_cnt != PRE_LIM) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_LIM) st <= FS_START;
              pre_cnt <= '0;
            end
          end
          FS_START: begin
            if (mdio_bit) begin
              st      <= FS_OPC;
              bit_cnt <= BIT_W'(1);
            end else begin
              st      <= FS_HUNT;
            end
          end
          FS_OPC: begin
            opc <= {opc[0], mdio_bit};
            if (bit_cnt == '0) begin
              st      <= FS_PHYAD;
              bit_cnt <= ADDR_LAST;
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
          FS_PHYAD: begin
            phy_q <= {phy_q[ADDR_W-2:0], mdio_bit};
            if (bit_cnt == '0) begin
              st      <= FS_REGAD;
              bit_cnt <= ADDR_LAST;
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
          FS_REGAD: begin
            reg_q <= reg_next;
            if (bit_cnt == '0) begin
              if (hdr_ok) begin
                st       <= FS_TURN1;
                is_rd    <= (opc == OPC_RD);
                cap_pend <= (opc == OPC_RD);
              end else begin
                st       <= FS_HUNT;
                pre_cnt  <= '0;
              end
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
          FS_TURN1: st <= FS_TURN2;
          FS_TURN2: begin
            st      <= FS_DATA;
            bit_cnt <= LAST_BIT;
          end
          FS_DATA: begin
            if (!is_rd) sh <= {sh[REG_W-2:0], mdio_bit};
            if (bit_cnt == '0) begin
              st      <= FS_HUNT;
              pre_cnt <= '0;
              wr_pend <= !is_rd;
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
          default: st <= FS_HUNT;
        endcase
      end
    end
  end

  // Launch side: new line values change on falling management-clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end else if (mdc_fall) begin
      mdio_oe  <= is_rd && ((st == FS_TURN2) || (st == FS_DATA));
      mdio_out <= (st == FS_DATA) ? sh[bit_cnt] : 1'b0;
    end
  end

  assign rd_stb   = cap_pend;
  assign wr_stb   = wr_pend;
  assign reg_addr = reg_q;
  assign wr_data  = sh;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter logic [23:0] ORG_CODE = 24'h00A0BE,
  parameter logic [5:0]  MODEL    = 6'h04,
  parameter logic [3:0]  REV      = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              link_up,
  input  logic              an_complete,
  input  logic              remote_fault,
  input  logic              jabber,
  input  logic              false_carrier,
  output logic              loopback_en,
  output logic              speed_sel,
  output logic              an_enable,
  output logic              power_down,
  output logic              full_duplex,
  output logic [1:0]        xover_mode,
  output logic              tx_tristate,
  output logic              ovr_gate,
  output logic              sw_rst,
  output logic              rf_latch
);

  localparam logic [23:0] STREAM = code_stream(ORG_CODE);
  localparam logic [REG_W-1:0] ID_HI = STREAM[21:6];
  localparam logic [REG_W-1:0] ID_LO = {STREAM[5:0], MODEL, REV};

  logic jab_latch;
  logic fc_latch;
  logic rd_stat;
  logic rd_poll;

  assign sw_rst  = wr_stb && (addr == RA_CTRL) && wr_data[15];
  assign rd_stat = rd_stb && (addr == RA_STAT);
  assign rd_poll = rd_stb && (addr == RA_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loopback_en <= 1'b0;
      speed_sel   <= 1'b1;
      an_enable   <= 1'b1;
      power_down  <= 1'b0;
      full_duplex <= 1'b0;
      xover_mode  <= 2'b11;
      tx_tristate <= 1'b0;
      ovr_gate    <= 1'b0;
    end else if (sw_rst) begin
      loopback_en <= 1'b0;
      speed_sel   <= 1'b1;
      an_enable   <= 1'b1;
      power_down  <= 1'b0;
      full_duplex <= 1'b0;
      xover_mode  <= 2'b11;
      tx_tristate <= 1'b0;
      ovr_gate    <= 1'b0;
    end else if (wr_stb) begin
      if (addr == RA_CTRL) begin
        loopback_en <= wr_data[14];
        speed_sel   <= wr_data[13];
        an_enable   <= wr_data[12];
        power_down  <= wr_data[11];
        full_duplex <= wr_data[8];
      end
      if (addr == RA_XCTL) begin
        tx_tristate <= wr_data[7];
        if (ovr_gate) xover_mode <= wr_data[9:8];
      end
      ovr_gate <= (addr == RA_GATE) && wr_data[15];
    end
  end

  // Latching-high status: hold once seen, fall back to live after a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_latch  <= 1'b0;
      jab_latch <= 1'b0;
      fc_latch  <= 1'b0;
    end else begin
      rf_latch  <= (rd_stat || sw_rst) ? remote_fault  : (rf_latch  | remote_fault);
      jab_latch <= (rd_stat || sw_rst) ? jabber        : (jab_latch | jabber);
      fc_latch  <= (rd_poll || sw_rst) ? false_carrier : (fc_latch  | false_carrier);
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      RA_CTRL:  rd_data = {1'b0, loopback_en, speed_sel, an_enable, power_down,
                           2'b00, full_duplex, 8'h00};
      RA_STAT:  rd_data = STAT_CAPS | {10'b0, an_complete, rf_latch | remote_fault,
                           1'b0, link_up, jab_latch | jabber, 1'b0};
      RA_ID_HI: rd_data = ID_HI;
      RA_ID_LO: rd_data = ID_LO;
      RA_GATE:  rd_data = {ovr_gate, 15'b0};
      RA_POLL:  rd_data = {speed_sel, full_duplex, 5'b0, fc_latch | false_carrier,
                           3'b0, an_complete, 3'b0, link_up};
      RA_XCTL:  rd_data = {6'b0, xover_mode, tx_tristate, 7'b0};
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_MIN     = 32,
  parameter logic [23:0] ORG_CODE    = 24'h00A0BE,
  parameter logic [5:0]  MODEL       = 6'h04,
  parameter logic [3:0]  REV         = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] phy_addr,
  input  logic       mdc,
  input  logic       mdio_in,
  output logic       mdio_out,
  output logic       mdio_oe,
  input  logic       link_up,
  input  logic       an_complete,
  input  logic       remote_fault,
  input  logic       jabber,
  input  logic       false_carrier,
  output logic       loopback_en,
  output logic       speed_sel,
  output logic       an_enable,
  output logic       power_down,
  output logic       full_duplex,
  output logic [1:0] xover_mode,
  output logic       tx_tristate
);

  logic [1:0]        line_s;
  logic              mdc_rise;
  logic              mdc_fall;
  logic              wr_stb;
  logic              rd_stb;
  logic [ADDR_W-1:0] reg_addr;
  logic [REG_W-1:0]  wr_data;
  logic [REG_W-1:0]  rd_data;
  logic              ovr_gate;
  logic              sw_rst;
  logic              rf_latch;
  logic              mdc_s_unused;

  mdio_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       ({mdio_in, mdc}),
    .dout      (line_s),
    .edge_rise (mdc_rise),
    .edge_fall (mdc_fall)
  );

  assign mdc_s_unused = line_s[0];

  mdio_frame_rx #(.PRE_MIN(PRE_MIN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall & ~mdc_s_unused),
    .mdio_bit (line_s[1]),
    .phy_addr (phy_addr),
    .rd_data  (rd_data),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  mdio_reg_bank #(.ORG_CODE(ORG_CODE), .MODEL(MODEL), .REV(REV)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_stb        (wr_stb),
    .rd_stb        (rd_stb),
    .addr          (reg_addr),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .link_up       (link_up),
    .an_complete   (an_complete),
    .remote_fault  (remote_fault),
    .jabber        (jabber),
    .false_carrier (false_carrier),
    .loopback_en   (loopback_en),
    .speed_sel     (speed_sel),
    .an_enable     (an_enable),
    .power_down    (power_down),
    .full_duplex   (full_duplex),
    .xover_mode    (xover_mode),
    .tx_tristate   (tx_tristate),
    .ovr_gate      (ovr_gate),
    .sw_rst        (sw_rst),
    .rf_latch      (rf_latch)
  );

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_oe,
  input logic              mdio_out,
  input logic              sw_rst,
  input logic              ovr_gate,
  input logic [1:0]        xover_mode,
  input logic              remote_fault,
  input logic              rf_latch,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              loopback_en,
  input logic              speed_sel,
  input logic              an_enable
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4: the first driven bit of a read is the zero turnaround bit.
  a_r4_turn_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  // R8: a software reset restores the control defaults.
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (speed_sel && an_enable && !loopback_en));

  // R11: without the gate the protected field cannot move.
  a_r11_gate_protects: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_gate && !sw_rst) |=> $stable(xover_mode));

  // R9: a seen condition is always captured.
  a_r9_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(remote_fault)) |-> rf_latch);

  // R9: a latched one holds until its register is read.
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rf_latch) && !$past(sw_rst) &&
     !($past(rd_stb) && ($past(reg_addr) == RA_STAT))) |-> rf_latch);

endmodule

bind mdio_mgmt_slave mdio_mgmt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mdio_oe      (mdio_oe),
  .mdio_out     (mdio_out),
  .sw_rst       (sw_rst),
  .ovr_gate     (ovr_gate),
  .xover_mode   (xover_mode),
  .remote_fault (remote_fault),
  .rf_latch     (rf_latch),
  .rd_stb       (rd_stb),
  .reg_addr     (reg_addr),
  .loopback_en  (loopback_en),
  .speed_sel    (speed_sel),
  .an_enable    (an_enable)
);

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

  localparam int HALF = 6;
  localparam logic [4:0] MY_ADDR = 5'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic mdio_in = 1'b1;
  logic link_up = 1'b0, an_complete = 1'b0, remote_fault = 1'b0;
  logic jabber = 1'b0, false_carrier = 1'b0;
  logic mdio_out, mdio_oe;
  logic loopback_en, speed_sel, an_enable, power_down, full_duplex, tx_tristate;
  logic [1:0] xover_mode;

  int checks = 0;
  int failures = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;

  // Behavioural model state
  logic m_loop, m_spd, m_an, m_pd, m_dup, m_ovr, m_tri, m_rf, m_jab, m_fc;
  logic [1:0] m_xov;

  always #5 clk = ~clk;

  mdio_mgmt_slave uut (
    .clk(clk), .rst_n(rst_n), .phy_addr(MY_ADDR), .mdc(mdc), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .link_up(link_up),
    .an_complete(an_complete), .remote_fault(remote_fault), .jabber(jabber),
    .false_carrier(false_carrier), .loopback_en(loopback_en), .speed_sel(speed_sel),
    .an_enable(an_enable), .power_down(power_down), .full_duplex(full_duplex),
    .xover_mode(xover_mode), .tx_tristate(tx_tristate)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R13: every clock between frames the line must be released.
  always @(negedge clk) begin
    if (quiet && !done) chk("R13 idle oe", {15'b0, mdio_oe}, 16'h0000);
  end

  task automatic model_defaults();
    m_loop = 0; m_spd = 1; m_an = 1; m_pd = 0; m_dup = 0;
    m_ovr = 0; m_xov = 2'b11; m_tri = 0;
    m_rf = remote_fault; m_jab = jabber; m_fc = false_carrier;
  endtask

  task automatic model_write(input int a, input logic [15:0] d);
    if (a == 0) begin
      if (d[15]) begin
        model_defaults();
        return;
      end
      m_loop = d[14]; m_spd = d[13]; m_an = d[12]; m_pd = d[11]; m_dup = d[8];
    end
    if (a == 19) begin
      m_tri = d[7];
      if (m_ovr) m_xov = d[9:8];
    end
    m_ovr = (a == 16) && d[15];
  endtask

  function automatic logic [15:0] exp_reg(input int a);
    logic [15:0] v;
    v = 16'h0000;
    case (a)
      0: begin v[14] = m_loop; v[13] = m_spd; v[12] = m_an; v[11] = m_pd; v[8] = m_dup; end
      1: begin
        v = 16'h7809; v[5] = an_complete; v[4] = m_rf | remote_fault;
        v[2] = link_up; v[1] = m_jab | jabber;
      end
      2: v = 16'h0015;
      3: v = 16'hF443;
      16: v[15] = m_ovr;
      17: begin
        v[15] = m_spd; v[14] = m_dup; v[8] = m_fc | false_carrier;
        v[4] = an_complete; v[0] = link_up;
      end
      19: begin v[9:8] = m_xov; v[7] = m_tri; end
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

  task automatic mbit(input logic b, output logic so, output logic soe);
    @(negedge clk);
    mdio_in = b;
    mdc = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    so = mdio_out;
    soe = mdio_oe;
    @(negedge clk);
    mdc = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic so, soe;
    for (int i = n - 1; i >= 0; i--) mbit(v[i], so, soe);
  endtask

  task automatic header(input int npre, input logic [1:0] op,
                        input logic [4:0] pa, input logic [4:0] ra);
    logic so, soe;
    quiet = 1'b0;
    mbit(1'b0, so, soe);
    mbit(1'b0, so, soe);
    for (int i = 0; i < npre; i++) mbit(1'b1, so, soe);
    send_bits({30'b0, 2'b01}, 2);
    send_bits({30'b0, op}, 2);
    send_bits({27'b0, pa}, 5);
    send_bits({27'b0, ra}, 5);
  endtask

  task automatic trailer();
    logic so, soe;
    mbit(1'b1, so, soe);
    mbit(1'b1, so, soe);
    quiet = 1'b1;
  endtask

  task automatic do_write(input int npre, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] d);
    header(npre, 2'b01, pa, ra);
    send_bits({30'b0, 2'b10}, 2);
    send_bits({16'b0, d}, 16);
    trailer();
    if (npre >= 32 && pa == MY_ADDR) model_write(int'(ra), d);
  endtask

  task automatic do_read(input logic [4:0] ra, input string tag);
    logic so, soe;
    logic [15:0] got, exp;
    exp = exp_reg(int'(ra));
    header(32, 2'b10, MY_ADDR, ra);
    mbit(1'b1, so, soe);
    chk("R4 turnaround1 oe", {15'b0, soe}, 16'h0000);
    mbit(1'b1, so, soe);
    chk("R4 turnaround2 oe/out", {14'b0, soe, so}, 16'h0002);
    got = '0;
    for (int i = 15; i >= 0; i--) begin
      mbit(1'b1, so, soe);
      got[i] = so & soe;
    end
    chk(tag, got, exp);
    trailer();
    if (ra == 5'd1) begin m_rf = remote_fault; m_jab = jabber; end
    if (ra == 5'd17) m_fc = false_carrier;
  endtask

  task automatic pulse_rf();
    @(negedge clk); remote_fault = 1'b1; m_rf = 1'b1;
    repeat (3) @(negedge clk); remote_fault = 1'b0;
  endtask

  task automatic pulse_fc();
    @(negedge clk); false_carrier = 1'b1; m_fc = 1'b1;
    repeat (3) @(negedge clk); false_carrier = 1'b0;
  endtask

  task automatic chk_ports(input string tag);
    chk(tag, {8'b0, loopback_en, speed_sel, an_enable, power_down, full_duplex,
              xover_mode, tx_tristate},
        {8'b0, m_loop, m_spd, m_an, m_pd, m_dup, m_xov, m_tri});
  endtask

  initial begin
    model_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 reset oe", {15'b0, mdio_oe}, 16'h0000);
    chk_ports("R12 reset ports");
    quiet = 1'b1;

    do_read(5'd0, "R5 reset ctrl 0x3000");
    do_read(5'd2, "R6 id high");
    do_read(5'd3, "R6 id low");
    do_read(5'd5, "R7 unmapped reads zero");

    do_write(32, MY_ADDR, 5'd0, 16'h4100);
    do_read(5'd0, "R3 write then read");
    chk_ports("R12 ports after write");

    do_write(32, 5'd3, 5'd0, 16'h0000);
    do_read(5'd0, "R2 foreign address ignored");
    do_write(31, MY_ADDR, 5'd0, 16'h0000);
    do_read(5'd0, "R1 short preamble ignored");

    do_write(32, MY_ADDR, 5'd0, 16'h7FFF);
    do_read(5'd0, "R7 reserved bits stay zero");
    chk_ports("R12 ports all fields");

    do_read(5'd1, "R10 status idle");
    pulse_rf();
    do_read(5'd1, "R9 remote fault latched");
    do_read(5'd1, "R9 remote fault cleared by read");
    @(negedge clk); jabber = 1'b1; m_jab = 1'b1;
    do_read(5'd1, "R9 jabber live");
    @(negedge clk); jabber = 1'b0;
    do_read(5'd1, "R9 jabber held after read");
    do_read(5'd1, "R9 jabber cleared");
    pulse_fc();
    do_read(5'd17, "R9 false carrier latched");
    do_read(5'd17, "R9 false carrier cleared");

    @(negedge clk); an_complete = 1'b1; link_up = 1'b1;
    do_read(5'd1, "R10 an complete in status");
    do_read(5'd17, "R10 an complete in poll");
    @(negedge clk); an_complete = 1'b0;
    do_read(5'd17, "R10 an complete live drop");

    do_read(5'd19, "R11 xctl default");
    do_write(32, MY_ADDR, 5'd19, 16'h0080);
    do_read(5'd19, "R11 protected without gate");
    do_write(32, MY_ADDR, 5'd16, 16'h8000);
    do_read(5'd16, "R11 gate reads set");
    do_write(32, MY_ADDR, 5'd19, 16'h0000);
    do_read(5'd19, "R11 gated write lands");
    chk_ports("R12 xover port");
    do_write(32, MY_ADDR, 5'd19, 16'h0200);
    do_read(5'd19, "R11 gate is one-shot");
    do_write(32, MY_ADDR, 5'd16, 16'h8000);
    do_write(32, MY_ADDR, 5'd0, 16'h0000);
    do_write(32, MY_ADDR, 5'd19, 16'h0100);
    do_read(5'd19, "R11 other write consumes gate");

    pulse_rf();
    do_write(32, MY_ADDR, 5'd0, 16'h8000);
    do_read(5'd0, "R8 soft reset defaults");
    do_read(5'd19, "R8 soft reset xctl");
    do_read(5'd16, "R8 soft reset gate");
    do_read(5'd1, "R8 soft reset latch to live");
    chk_ports("R8 ports after soft reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule